// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block sits at the heart of an eight-line interrupt controller. Every cycle it samples eight request inputs into a request register. Each line can be set to capture a rising edge or to follow the input level. A mask register hides chosen lines. The block picks the best unmasked pending request under a rotating priority order and compares it with the best line that is already in service. It raises its interrupt output only when the new request would preempt, and it reports the winning line number.

An acknowledge strobe from the surrounding controller takes the current winner. With normal end-of-interrupt handling, the acknowledge marks that line as in service. With automatic end-of-interrupt handling, the acknowledge marks nothing as in service and can rotate the priority order. The mode bits come in as plain inputs: automatic end-of-interrupt, rotation on automatic end-of-interrupt, special mask, special nesting and cascade-master. Command decoding, register readback and vector formation belong to the surrounding controller.

Top module: `prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears the request, in-service, mask and previous-input registers and sets the rotation offset to 0. Out of reset, `intOut` is 0 and `winLine` is 0.
- R2: On a line whose `trigLevel` bit is 0, a 0-to-1 change of `reqIn` sets its request bit at the next clock edge. Holding the input high does not set the bit again once it has been cleared.
- R3: On a line whose `trigLevel` bit is 1, the request bit equals the value of `reqIn` at the previous clock edge.
- R4: A line is pending when its request bit is 1 and its mask bit is 0. A write with `maskWr` high loads `maskVal` into the mask at the clock edge. When no line is pending, `intOut` is 0.
- R5: Priority level k (0 is highest) belongs to line (k + rotation offset) mod 8. The pending line with the lowest level wins. `winLine` gives its number while `intOut` is 1, and is 0 otherwise. Both outputs are combinational from the registers.
- R6: `intOut` is 1 only if the winning pending level is strictly lower in number than the lowest level among the in-service lines. A request at the same level as, or a lower priority than, an in-service line is held off.
- R7: When `ackIn` is high while `intOut` is 1 and `autoEoi` is 0, the in-service bit of `winLine` is set at the clock edge. An acknowledge clears the request bit of an edge-triggered line and leaves the request bit of a level-triggered line set.
- R8: When `ackIn` is high while `intOut` is 1 and `autoEoi` is 1, no in-service bit is set. If `rotateAeoi` is also 1, the rotation offset becomes (`winLine` + 1) mod 8, so that line becomes the lowest priority.
- R9: With `specialMask` high, masked lines are left out of the in-service set when the current level is worked out.
- R10: With `nestedMode` and `isMaster` both high, in-service bit 2 (the cascade line) is left out of the current-level computation.
- R11: `ackIn` while `intOut` is 0 has no effect on the request, in-service or rotation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 8 | Raw interrupt request inputs |
| trigLevel | input | 8 | Per-line trigger mode: 1 = level, 0 = edge |
| maskWr | input | 1 | Load strobe for the mask register |
| maskVal | input | 8 | New mask value (1 = masked) |
| autoEoi | input | 1 | Automatic end-of-interrupt mode |
| rotateAeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| specialMask | input | 1 | Special mask mode |
| nestedMode | input | 1 | Special fully nested mode |
| isMaster | input | 1 | Instance is the cascade master |
| ackIn | input | 1 | Interrupt acknowledge strobe |
| intOut | output | 1 | Interrupt request to the processor |
| winLine | output | 3 | Winning line number |

## Verification
A change on `reqIn` or `maskVal` passes through one register, so its effect on `intOut` and `winLine` is due one clock edge later. An acknowledge also updates the in-service and rotation state at one edge, and the outputs reflect that right after the edge. Mode inputs act combinationally on the outputs, with no edge between them. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples the outputs on the next falling edge. Each check therefore looks at the state that the single edge just produced.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int LINE_W = 3;
  localparam int LINES  = 1 << LINE_W;
  localparam int LVL_W  = LINE_W + 1;

  // strobes from control to datapath for one acknowledge
  typedef struct packed {
    logic              take;    // acknowledge accepted this cycle
    logic              setIsr;  // mark line in service
    logic              rotate;  // move rotation offset past line
    logic [LINE_W-1:0] line;    // acknowledged line
  } ackCmd_t;
endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irr,
  input  logic [LINES-1:0]  isr,
  input  logic [LINES-1:0]  imr,
  input  logic [LINE_W-1:0] rotOff,
  input  logic              autoEoi,
  input  logic              rotateAeoi,
  input  logic              specialMask,
  input  logic              nestedMode,
  input  logic              isMaster,
  input  logic              ackIn,
  output logic              intOut,
  output logic [LINE_W-1:0] winLine,
  output ackCmd_t           cmd
);
  // lowest level present in a set under the current rotation; LINES = none
  function automatic logic [LVL_W-1:0] scanLevel(input logic [LINES-1:0] set,
                                                 input logic [LINE_W-1:0] rot);
    logic [LVL_W-1:0] lvl;
    lvl = LVL_W'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      if (set[LINE_W'(k) + rot]) lvl = LVL_W'(k);
    end
    return lvl;
  endfunction

  logic [LINES-1:0] pending;
  logic [LINES-1:0] svcSet;
  logic [LVL_W-1:0] reqLvl;
  logic [LVL_W-1:0] curLvl;

  always_comb begin
    pending = irr & ~imr;
    svcSet  = isr;
    if (specialMask) svcSet = svcSet & ~imr;
    if (nestedMode && isMaster) svcSet[CASCADE_LINE] = 1'b0;
    reqLvl  = scanLevel(pending, rotOff);
    curLvl  = scanLevel(svcSet, rotOff);
    intOut  = (reqLvl < curLvl);
    winLine = intOut ? (reqLvl[LINE_W-1:0] + rotOff) : '0;
  end

  always_comb begin
    cmd.take   = ackIn && intOut;
    cmd.setIsr = ackIn && intOut && !autoEoi;
    cmd.rotate = ackIn && intOut && autoEoi && rotateAeoi;
    cmd.line   = winLine;
  end

  // winner must really be pending and unmasked
  assert_win_pending_R5: assert property (@(posedge clk) disable iff (rst)
    intOut |-> (irr[winLine] && !imr[winLine]));

  // with plain nesting a line already in service can never win again
  assert_strict_R6: assert property (@(posedge clk) disable iff (rst)
    (intOut && !specialMask && !(nestedMode && isMaster)) |-> !isr[winLine]);

  // empty pending set never raises the output
  assert_empty_R4: assert property (@(posedge clk) disable iff (rst)
    ((irr & ~imr) == '0) |-> !intOut);
endmodule

// File: rtl/prio_dp.sv
module prio_dp
  import prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  reqIn,
  input  logic [LINES-1:0]  trigLevel,
  input  logic              maskWr,
  input  logic [LINES-1:0]  maskVal,
  input  ackCmd_t           cmd,
  output logic [LINES-1:0]  irr,
  output logic [LINES-1:0]  isr,
  output logic [LINES-1:0]  imr,
  output logic [LINE_W-1:0] rotOff
);
  logic [LINES-1:0] prevLvl;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irr[i] <= 1'b0;
      end else if (trigLevel[i]) begin
        irr[i] <= reqIn[i];
      end else if (reqIn[i] && !prevLvl[i]) begin
        irr[i] <= 1'b1;
      end else if (cmd.take && cmd.line == LINE_W'(i)) begin
        irr[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLvl <= '0;
      isr     <= '0;
      imr     <= '0;
      rotOff  <= '0;
    end else begin
      prevLvl <= reqIn;
      if (maskWr) imr <= maskVal;
      if (cmd.setIsr) isr[cmd.line] <= 1'b1;
      if (cmd.rotate) rotOff <= cmd.line + LINE_W'(1);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (irr == '0 && isr == '0 && imr == '0 && rotOff == '0));

  assert_level_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((irr ^ $past(reqIn)) & $past(trigLevel)) == '0));

  assert_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(reqIn & ~prevLvl & ~trigLevel) & ~irr) == '0));

  assert_isr_R7: assert property (@(posedge clk) disable iff (rst)
    cmd.setIsr |=> isr[$past(cmd.line)]);

  assert_rotate_R8: assert property (@(posedge clk) disable iff (rst)
    cmd.rotate |=> (rotOff == $past(cmd.line) + LINE_W'(1)));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  reqIn,
  input  logic [LINES-1:0]  trigLevel,
  input  logic              maskWr,
  input  logic [LINES-1:0]  maskVal,
  input  logic              autoEoi,
  input  logic              rotateAeoi,
  input  logic              specialMask,
  input  logic              nestedMode,
  input  logic              isMaster,
  input  logic              ackIn,
  output logic              intOut,
  output logic [LINE_W-1:0] winLine
);
  logic [LINES-1:0]  irr, isr, imr;
  logic [LINE_W-1:0] rotOff;
  ackCmd_t           cmd;

  prio_ctrl #(.CASCADE_LINE(CASCADE_LINE)) u_ctrl (
    .clk(clk), .rst(rst), .irr(irr), .isr(isr), .imr(imr), .rotOff(rotOff),
    .autoEoi(autoEoi), .rotateAeoi(rotateAeoi), .specialMask(specialMask),
    .nestedMode(nestedMode), .isMaster(isMaster), .ackIn(ackIn),
    .intOut(intOut), .winLine(winLine), .cmd(cmd)
  );

  prio_dp u_dp (
    .clk(clk), .rst(rst), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskWr(maskWr), .maskVal(maskVal), .cmd(cmd),
    .irr(irr), .isr(isr), .imr(imr), .rotOff(rotOff)
  );

  // acknowledge with nothing signalled leaves service state alone
  assert_noack_R11: assert property (@(posedge clk) disable iff (rst)
    (ackIn && !intOut) |=> ($stable(isr) && $stable(rotOff)));
endmodule

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reqIn = '0, trigLevel = '0, maskVal = '0;
  logic       maskWr = 0, autoEoi = 0, rotateAeoi = 0, specialMask = 0;
  logic       nestedMode = 0, isMaster = 0, ackIn = 0;
  logic       intOut;
  logic [2:0] winLine;
  int         nChecks = 0, nFails = 0;
  bit         done = 0;

  always #4 clk = ~clk;  // 125 MHz

  prio_resolver u_prio_resolver (
    .clk(clk), .rst(rst), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskWr(maskWr), .maskVal(maskVal), .autoEoi(autoEoi),
    .rotateAeoi(rotateAeoi), .specialMask(specialMask),
    .nestedMode(nestedMode), .isMaster(isMaster), .ackIn(ackIn),
    .intOut(intOut), .winLine(winLine)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOut(string tag, logic expInt, logic [2:0] expLine);
    nChecks++;
    if (intOut !== expInt || winLine !== expLine) begin
      nFails++;
      $display("FAIL %s: intOut=%0b winLine=%0d expected intOut=%0b winLine=%0d",
               tag, intOut, winLine, expInt, expLine);
    end
  endtask

  task automatic doReset();
    reqIn = '0; trigLevel = '0; maskWr = 0; maskVal = '0; autoEoi = 0;
    rotateAeoi = 0; specialMask = 0; nestedMode = 0; isMaster = 0; ackIn = 0;
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic ack();
    ackIn = 1; step(); ackIn = 0;
  endtask

  task automatic setMask(logic [7:0] v);
    maskWr = 1; maskVal = v; step(); maskWr = 0;
  endtask

  task automatic testReset();
    doReset();
    expectOut("R1 reset state", 0, 0);
    reqIn = 8'h20; step();
    expectOut("R2 edge before reset", 1, 5);
    reqIn = '0; doReset();
    expectOut("R1 reset clears request", 0, 0);
  endtask

  task automatic testEdge();
    doReset();
    autoEoi = 1;
    reqIn[3] = 1; step();
    expectOut("R2 rising edge captured", 1, 3);
    ack();
    expectOut("R2 held input not recaptured, R8 no in-service", 0, 0);
    reqIn[3] = 0; step();
    reqIn[3] = 1; step();
    expectOut("R2 new edge recaptured", 1, 3);
  endtask

  task automatic testNested();
    doReset();
    reqIn = 8'h24; step();
    expectOut("R5 fixed order lowest line wins", 1, 2);
    ack();
    expectOut("R7 in-service blocks lower priority", 0, 0);
    reqIn[1] = 1; step();
    expectOut("R6 higher priority preempts", 1, 1);
  endtask

  task automatic testEqual();
    doReset();
    reqIn[3] = 1; step(); ack();
    reqIn[3] = 0; step();
    reqIn[3] = 1; step();
    expectOut("R6 same level held off", 0, 0);
  endtask

  task automatic testLevel();
    doReset();
    trigLevel[4] = 1; autoEoi = 1;
    reqIn[4] = 1; step();
    expectOut("R3 level request follows input", 1, 4);
    ack();
    expectOut("R7 level request kept after ack", 1, 4);
    reqIn[4] = 0; step();
    expectOut("R3 level request drops with input", 0, 0);
  endtask

  task automatic testMask();
    doReset();
    setMask(8'h02);
    reqIn[1] = 1; step();
    expectOut("R4 masked line not signalled", 0, 0);
    ack();
    setMask(8'h00);
    expectOut("R11 ignored ack kept request, R4 unmask", 1, 1);
  endtask

  task automatic testRotate();
    doReset();
    autoEoi = 1; rotateAeoi = 1;
    reqIn[6] = 1; step();
    expectOut("R8 pre-rotation winner", 1, 6);
    ack();
    expectOut("R8 auto eoi leaves nothing", 0, 0);
    reqIn = 8'h81; step();
    expectOut("R8 R5 line 7 now highest after rotation", 1, 7);
  endtask

  task automatic testSpecialMask();
    doReset();
    reqIn[3] = 1; step(); ack();
    reqIn[5] = 1; step();
    expectOut("R9 in-service line 3 blocks 5", 0, 0);
    setMask(8'h08);
    expectOut("R9 mask alone does not unblock", 0, 0);
    specialMask = 1; step();
    expectOut("R9 special mask drops masked in-service", 1, 5);
  endtask

  task automatic testCascade();
    doReset();
    reqIn[2] = 1; step(); ack();
    reqIn[4] = 1; step();
    expectOut("R10 cascade in service blocks 4", 0, 0);
    nestedMode = 1; isMaster = 1; step();
    expectOut("R10 master nesting ignores cascade bit", 1, 4);
    isMaster = 0; step();
    expectOut("R10 non-master keeps cascade bit", 0, 0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testEdge();
    testNested();
    testEqual();
    testLevel();
    testMask();
    testRotate();
    testSpecialMask();
    testCascade();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule